// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Backlog

This block produces the refresh cycles of a synchronous DRAM controller. Once the configuration is loaded, it starts an interval timer and opens a startup window. During that window the block performs refreshes only and holds its `init_done` output low, so the access sequencer knows it must refuse memory accesses. Apart from this window, the memory needs no extra warm-up cycles.

Each time the timer expires, a refresh is added to a small backlog counter. The scheduler then asks the access sequencer for the bus with `rf_req`. While the sequencer keeps `rf_gnt` low, for example during a long page access, further expiries accumulate in the backlog, up to six. A seventh expiry is dropped and sets a sticky overflow flag. After a grant, the scheduler keeps the bus and issues every queued refresh back to back, with a fixed precharge gap between them. It releases `rf_req` only when the backlog is empty.

The refresh style is chosen at configuration time: all enabled banks strobed together, banks strobed one clock apart, or CAS-before-RAS. The RAS strobes serve one, two or four banks.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, `rf_req`=0, `init_done`=0, `pend_cnt`=0, `pend_ovf`=0, and every `ras_n` bit and `cas_n` are 1 (strobes are active low).
- R2: `init_done` stays 0 for exactly INIT_CYCLES clock edges after the edge that samples `cfg_load`=1, then reads 1 until the next `cfg_load`. A new `cfg_load` restarts the window and clears the backlog and the overflow flag.
- R3: After `cfg_load`, a refresh request is added to the backlog every `cfg_interval` cycles, the first one `cfg_interval` edges after the load edge. Requests are raised during the startup window as well, so `rf_req` can be 1 while `init_done` is 0.
- R4: While no grant is given, `pend_cnt` counts the requests up to 6 and then saturates. A request that arrives at 6 sets `pend_ovf`, which stays 1 until `cfg_load` or reset.
- R5: A grant is the edge that samples `rf_gnt`=1 while `rf_req`=1. From that edge the block issues every pending refresh consecutively, each followed by PRECHG (2) cycles with all strobes high. It holds `rf_req`=1 until the backlog is empty, then drops it on the following edge.
- R6: `cfg_style`=0 (all banks): in cycles 0..L-1 of each refresh, every enabled bank's `ras_n` is 0 and `cas_n` stays 1. L is `cfg_ras_low`, with 0 treated as 1. Cycle 0 is the cycle after the grant edge, or the cycle after the previous refresh's precharge.
- R7: `cfg_style`=1 (staggered): bank b's `ras_n` is 0 in cycles b..b+L-1, so a refresh lasts L+N-1 cycles, where N is the number of enabled banks.
- R8: `cfg_style`=2 (CAS-before-RAS): `cas_n` is 0 in cycles 0..L and the enabled banks' `ras_n` are 0 in cycles 1..L, so CAS leads RAS by one clock and both release together.
- R9: `cfg_banks` selects the enabled banks: 0 enables bank 0, 1 enables banks 0-1, 2 or 3 enables banks 0-3. A bank that is not enabled keeps `ras_n`=1.
- R10: `rf_gnt` has no effect while `rf_req`=0. The strobes stay high and the backlog is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle pulse that loads the configuration and starts the startup window |
| cfg_style | input | 2 | Refresh style: 0 all banks, 1 staggered, 2 CAS-before-RAS |
| cfg_banks | input | 2 | Enabled bank count: 0 one, 1 two, 2/3 four |
| cfg_ras_low | input | RLW | RAS low time in cycles (0 acts as 1) |
| cfg_interval | input | IVW | Cycles between refresh requests |
| rf_gnt | input | 1 | Bus grant from the access sequencer |
| rf_req | output | 1 | Bus request; high from the first pending refresh until the backlog is drained |
| init_done | output | 1 | High once the startup window has ended |
| pend_cnt | output | CW | Number of queued refreshes |
| pend_ovf | output | 1 | Sticky flag: a request was lost at full backlog |
| ras_n | output | NUM_BANKS | Per-bank RAS strobes, active low |
| cas_n | output | 1 | CAS strobe for CAS-before-RAS refresh, active low |

## Verification
The main function is exercised with four kinds of stimulus. A grant withheld across several timer expiries shows that requests are counted, saturate at six and set the overflow flag. A grant given with three refreshes queued shows that the burst really runs back to back, with exactly the precharge gap and a prompt release of `rf_req`. Single granted refreshes in each style and bank count produce a cycle-by-cycle strobe pattern that separates all-bank, staggered and CAS-leading behaviour and shows that disabled banks stay quiet. A grant held high while nothing is pending shows that the handshake ignores it.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_STRB = 2'd2,
        ST_PRE  = 2'd3
    } rf_state_e;

    localparam logic [1:0] STY_ALL  = 2'd0;
    localparam logic [1:0] STY_STAG = 2'd1;
    localparam logic [1:0] STY_CBR  = 2'd2;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int IVW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [IVW-1:0] ival,
    output logic           tick
);
    typedef struct packed {
        logic           run;
        logic [IVW-1:0] per;
        logic [IVW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.per = ival;
            t_d.cnt = (ival == '0) ? '0 : ival - 1'b1;
        end else if (t_q.run) begin
            if (t_q.cnt == '0)
                t_d.cnt = (t_q.per == '0) ? '0 : t_q.per - 1'b1;
            else
                t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tick = t_q.run && (t_q.cnt == '0);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int MAX_PEND = 6,
    localparam int CW = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          ovf
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } bl_t;

    bl_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d = '0;
        end else if (inc && !dec) begin
            if (b_q.cnt == CW'(MAX_PEND)) b_d.ovf = 1'b1;
            else                          b_d.cnt = b_q.cnt + 1'b1;
        end else if (dec && !inc && b_q.cnt != '0) begin
            b_d.cnt = b_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign cnt = b_q.cnt;
    assign ovf = b_q.ovf;

    // R4: the backlog never exceeds its limit
    a_r4_cnt_max: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.cnt <= CW'(MAX_PEND));

    // R4: the overflow flag is sticky until cleared
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.ovf && !clr) |=> b_q.ovf);

endmodule

// File: rtl/rfsh_strobe_gen.sv
module rfsh_strobe_gen
    import rfsh_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int RLW       = 4,
    parameter int PW        = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic [1:0]           style,
    input  logic [1:0]           bank_sel,
    input  logic [RLW-1:0]       ras_low,
    input  logic [PW-1:0]        phase,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic                 cas_n,
    output logic [PW-1:0]        phase_len
);
    localparam int NB4 = (NUM_BANKS < 4) ? NUM_BANKS : 4;
    localparam int NB2 = (NUM_BANKS < 2) ? NUM_BANKS : 2;

    logic [PW-1:0] low_len;
    logic [PW-1:0] nbk;

    always_comb begin
        low_len = (ras_low == '0) ? PW'(1) : PW'(ras_low);
        case (bank_sel)
            2'd0:    nbk = PW'(1);
            2'd1:    nbk = PW'(NB2);
            default: nbk = PW'(NB4);
        endcase
        case (style)
            STY_STAG: phase_len = low_len + nbk - PW'(1);
            STY_CBR:  phase_len = low_len + PW'(1);
            default:  phase_len = low_len;
        endcase
        cas_n = !(active && style == STY_CBR && phase <= low_len);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        always_comb begin
            case (style)
                STY_STAG: hit = (phase >= PW'(b)) && (phase < PW'(b) + low_len);
                STY_CBR:  hit = (phase >= PW'(1)) && (phase <= low_len);
                default:  hit = (phase < low_len);
            endcase
            ras_n[b] = !(active && (PW'(b) < nbk) && hit);
        end
    end

    // R8: in CAS-before-RAS mode CAS is already low the cycle before RAS falls
    a_r8_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STY_CBR && ras_n != '1 && $past(ras_n) == '1) |-> !$past(cas_n));

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int INIT_CYCLES = 7_500_000,
    parameter int NUM_BANKS   = 4,
    parameter int MAX_PEND    = 6,
    parameter int RLW         = 4,
    parameter int IVW         = 16,
    parameter int PRECHG      = 2,
    localparam int CW = $clog2(MAX_PEND + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [1:0]           cfg_style,
    input  logic [1:0]           cfg_banks,
    input  logic [RLW-1:0]       cfg_ras_low,
    input  logic [IVW-1:0]       cfg_interval,
    input  logic                 rf_gnt,
    output logic                 rf_req,
    output logic                 init_done,
    output logic [CW-1:0]        pend_cnt,
    output logic                 pend_ovf,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic                 cas_n
);
    localparam int IW  = $clog2(INIT_CYCLES + 1);
    localparam int PW  = RLW + $clog2(NUM_BANKS + 1) + 1;
    localparam int PCW = (PRECHG < 2) ? 1 : $clog2(PRECHG);

    typedef struct packed {
        logic           cfgd;
        logic [1:0]     style;
        logic [1:0]     bsel;
        logic [RLW-1:0] rlow;
        logic [IW-1:0]  init;
        rf_state_e      st;
        logic [PW-1:0]  ph;
        logic [PCW-1:0] pre;
    } ctl_t;

    ctl_t s_d, s_q;
    logic          tick;
    logic          take;
    logic [PW-1:0] len;

    rfsh_interval_timer #(.IVW(IVW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cfg_load),
        .ival  (cfg_interval),
        .tick  (tick)
    );

    rfsh_backlog #(.MAX_PEND(MAX_PEND)) u_bl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_load),
        .inc   (tick),
        .dec   (take),
        .cnt   (pend_cnt),
        .ovf   (pend_ovf)
    );

    rfsh_strobe_gen #(.NUM_BANKS(NUM_BANKS), .RLW(RLW), .PW(PW)) u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (s_q.st == ST_STRB),
        .style     (s_q.style),
        .bank_sel  (s_q.bsel),
        .ras_low   (s_q.rlow),
        .phase     (s_q.ph),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .phase_len (len)
    );

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        if (cfg_load) begin
            s_d.cfgd  = 1'b1;
            s_d.style = cfg_style;
            s_d.bsel  = cfg_banks;
            s_d.rlow  = cfg_ras_low;
            s_d.init  = IW'(INIT_CYCLES);
            s_d.st    = ST_IDLE;
            s_d.ph    = '0;
            s_d.pre   = '0;
        end else begin
            if (s_q.cfgd && s_q.init != '0) s_d.init = s_q.init - 1'b1;
            case (s_q.st)
                ST_IDLE: if (pend_cnt != '0) s_d.st = ST_WAIT;
                ST_WAIT: begin
                    if (rf_gnt && pend_cnt != '0) begin
                        take   = 1'b1;
                        s_d.st = ST_STRB;
                        s_d.ph = '0;
                    end
                end
                ST_STRB: begin
                    if (s_q.ph >= len - PW'(1)) begin
                        s_d.st  = ST_PRE;
                        s_d.pre = '0;
                    end else begin
                        s_d.ph = s_q.ph + 1'b1;
                    end
                end
                default: begin
                    if (s_q.pre == PCW'(PRECHG - 1)) begin
                        if (pend_cnt != '0) begin
                            take   = 1'b1;
                            s_d.st = ST_STRB;
                            s_d.ph = '0;
                        end else begin
                            s_d.st = ST_IDLE;
                        end
                    end else begin
                        s_d.pre = s_q.pre + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rf_req    = (s_q.st != ST_IDLE);
    assign init_done = s_q.cfgd && (s_q.init == '0);

    // R5: a queued refresh always keeps the bus request up
    a_r5_req_while_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt != '0 && !cfg_load) |=> rf_req);

    // R10: without a bus request no strobe moves
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_req |-> (ras_n == '1 && cas_n));

    // R2: once the startup window closes it stays closed until a reload
    a_r2_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !cfg_load) |=> init_done);

endmodule

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;
    localparam int INIT = 40;
    localparam int NB   = 4;
    localparam int PRE  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_style = 2'd0;
    logic [1:0] cfg_banks = 2'd0;
    logic [3:0] cfg_ras_low = 4'd1;
    logic [15:0] cfg_interval = 16'd10;
    logic       rf_gnt = 1'b0;
    logic       rf_req, init_done, pend_ovf, cas_n;
    logic [2:0] pend_cnt;
    logic [NB-1:0] ras_n;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rfsh_sched #(.INIT_CYCLES(INIT), .NUM_BANKS(NB), .PRECHG(PRE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_style(cfg_style),
        .cfg_banks(cfg_banks), .cfg_ras_low(cfg_ras_low), .cfg_interval(cfg_interval),
        .rf_gnt(rf_gnt), .rf_req(rf_req), .init_done(init_done), .pend_cnt(pend_cnt),
        .pend_ovf(pend_ovf), .ras_n(ras_n), .cas_n(cas_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // leaves the bench at the negedge after the load edge
    task automatic load(input logic [1:0] sty, input logic [1:0] bk,
                        input logic [3:0] rl, input logic [15:0] iv);
        @(negedge clk);
        cfg_style = sty; cfg_banks = bk; cfg_ras_low = rl; cfg_interval = iv;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // leaves the bench at the negedge after the grant edge (cycle 0)
    task automatic grant_when_req();
        for (int k = 0; k < 500 && !rf_req; k++) @(negedge clk);
        rf_gnt = 1'b1;
        @(negedge clk);
        rf_gnt = 1'b0;
    endtask

    function automatic int nbanks(input logic [1:0] bk);
        return (bk == 2'd0) ? 1 : (bk == 2'd1) ? 2 : 4;
    endfunction

    task automatic t_reset();
        chk(rf_req == 0 && init_done == 0 && pend_cnt == 0 && pend_ovf == 0,
            "R1 reset outputs", int'(rf_req) + int'(init_done) + int'(pend_cnt), 0);
        chk(ras_n == '1 && cas_n == 1'b1, "R1 reset strobes", int'({ras_n, cas_n}), 31);
    endtask

    task automatic t_init_and_backlog();
        load(2'd0, 2'd2, 4'd2, 16'd10);
        repeat (12) @(negedge clk);
        chk(pend_cnt == 1, "R3 first request after interval", int'(pend_cnt), 1);
        chk(rf_req == 1 && init_done == 0, "R3 request inside startup window",
            int'({rf_req, init_done}), 2);
        repeat (10) @(negedge clk);
        chk(pend_cnt == 2, "R4 backlog second", int'(pend_cnt), 2);
        repeat (10) @(negedge clk);
        chk(pend_cnt == 3, "R4 backlog third", int'(pend_cnt), 3);
        repeat (7) @(negedge clk);   // after edge 39
        chk(init_done == 0, "R2 window still open at INIT-1", int'(init_done), 0);
        @(negedge clk);              // after edge 40
        chk(init_done == 1, "R2 window closes at INIT", int'(init_done), 1);
        repeat (22) @(negedge clk);  // after edge 62
        chk(pend_cnt == 6 && pend_ovf == 0, "R4 saturate at six, no overflow yet",
            int'(pend_cnt) * 10 + int'(pend_ovf), 60);
        repeat (10) @(negedge clk);  // after edge 72
        chk(pend_cnt == 6 && pend_ovf == 1, "R4 seventh request sets overflow",
            int'(pend_cnt) * 10 + int'(pend_ovf), 61);
        repeat (5) @(negedge clk);
        chk(pend_ovf == 1, "R4 overflow sticky", int'(pend_ovf), 1);
        load(2'd0, 2'd2, 4'd2, 16'd100);
        chk(pend_ovf == 0 && pend_cnt == 0 && init_done == 0,
            "R2 reload clears backlog and restarts window",
            int'(pend_ovf) + int'(pend_cnt) + int'(init_done), 0);
    endtask

    task automatic t_burst();
        int bad = 0;
        load(2'd0, 2'd2, 4'd3, 16'd40);
        for (int k = 0; k < 200 && pend_cnt != 3; k++) @(negedge clk);
        chk(pend_cnt == 3 && rf_req == 1, "R5 three queued before grant", int'(pend_cnt), 3);
        rf_gnt = 1'b1;
        @(negedge clk);
        rf_gnt = 1'b0;
        for (int i = 0; i < 15; i++) begin
            logic [NB-1:0] e = ((i % 5) < 3) ? '0 : '1;
            if (ras_n != e || cas_n != 1'b1 || rf_req != 1'b1) begin
                bad++;
                $display("FAIL R5/R6 burst cycle %0d actual=%b expected=%b", i, ras_n, e);
            end
            @(negedge clk);
        end
        chk(bad == 0, "R6 burst strobe pattern", bad, 0);
        chk(rf_req == 0 && pend_cnt == 0, "R5 request drops when drained",
            int'(rf_req) + int'(pend_cnt), 0);
    endtask

    task automatic t_single(input logic [1:0] sty, input logic [1:0] bk,
                            input logic [3:0] rl, input string tag);
        int bad = 0;
        int n = nbanks(bk);
        int len = (sty == 2'd1) ? int'(rl) + n - 1 : (sty == 2'd2) ? int'(rl) + 1 : int'(rl);
        load(sty, bk, rl, 16'd30);
        grant_when_req();
        for (int i = 0; i < len + PRE; i++) begin
            logic [NB-1:0] er = '1;
            logic ec = 1'b1;
            for (int b = 0; b < NB; b++) begin
                bit lo;
                if (sty == 2'd1)      lo = (i >= b) && (i < b + int'(rl));
                else if (sty == 2'd2) lo = (i >= 1) && (i <= int'(rl));
                else                  lo = (i < int'(rl));
                if (b < n && lo) er[b] = 1'b0;
            end
            if (sty == 2'd2 && i <= int'(rl)) ec = 1'b0;
            if (ras_n != er || cas_n != ec) begin
                bad++;
                $display("FAIL %s cycle %0d actual=%b/%b expected=%b/%b",
                         tag, i, ras_n, cas_n, er, ec);
            end
            @(negedge clk);
        end
        chk(bad == 0, tag, bad, 0);
        chk(rf_req == 0, "R5 single refresh releases bus", int'(rf_req), 0);
    endtask

    task automatic t_ignore_grant();
        int bad = 0;
        load(2'd0, 2'd2, 4'd2, 16'd100);
        rf_gnt = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (rf_req != 0 || ras_n != '1 || cas_n != 1 || pend_cnt != 0) bad++;
        end
        rf_gnt = 1'b0;
        chk(bad == 0, "R10 grant without request ignored", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_init_and_backlog();
        t_burst();
        t_single(2'd0, 2'd0, 4'd2, "R6 R9 all-bank refresh, one bank");
        t_single(2'd1, 2'd2, 4'd2, "R7 staggered refresh, four banks");
        t_single(2'd1, 2'd1, 4'd3, "R7 R9 staggered refresh, two banks");
        t_single(2'd2, 2'd1, 4'd2, "R8 R9 CAS-before-RAS, two banks");
        t_ignore_grant();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule